// File: doc/BRIEF.md
# Posted-CAS read latency tracker

This block tracks when read data from a DDR2-style SDRAM device appears once posted CAS additive latency is in use. A READ strobed into the block is first held for the additive latency (AL) before it reaches the internal column path. The block marks that moment with a one-cycle issue pulse. The CAS latency (CL) then runs, after which a data-valid window opens. The window lasts half the burst length in clocks, and the command's tag goes with it. Several READs can be outstanding at once, and they come out in the order they went in.

Latency and burst settings arrive through a small configuration write port, and every latency is a whole number of clocks. The block checks each write. A write that asks for a reserved additive latency, or for a CAS latency outside the supported range, is refused and flagged. A write that arrives while any READ is still in flight is also refused and flagged. A refused write leaves the previous settings in force.

Top module: `rdlt_tracker`

## Requirements
- R1: With AL = 0, a READ registered at clock edge n has its data-valid window begin at edge n+CL. The same holds for CL = 3 and CL = 4.
- R2: `issue` goes high for exactly one clock beginning at edge n+AL after the READ edge n. With AL = 0 that is the same edge that registers the READ.
- R3: For AL > 0 the data-valid window begins at edge n+AL+CL, for any AL from 0 to 4 and any CL from 3 to 7.
- R4: The legal `cfg_al` codes are 0 to 4. A write with code 5, 6 or 7 raises `err_illegal` for one clock after the write edge and leaves the settings unchanged.
- R5: The legal `cfg_cl` codes are 3 to 7. A write outside that range raises `err_illegal` for one clock and leaves the settings unchanged.
- R6: `dv` stays high for BL/2 consecutive clocks per READ. When `cfg_bl8` = 0 the burst length is 4, giving a 2-clock window. When `cfg_bl8` = 1 it is 8, giving a 4-clock window.
- R7: READs spaced exactly BL/2 clocks apart produce one unbroken `dv` run, with the tags delivered in command order.
- R8: `issue_tag` carries the `rd_tag` of the READ being issued. `dv_tag` carries the `rd_tag` of the READ whose window is current.
- R9: A configuration write made while a READ is in flight, or on the same edge as a READ, raises `err_busy` for one clock and is ignored. `err_busy` takes priority over `err_illegal`.
- R10: After reset all outputs are low and the settings are AL = 0, CL = 3, BL = 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_al | input | 3 | Requested additive latency (0..4 legal) |
| cfg_cl | input | 3 | Requested CAS latency (3..7 legal) |
| cfg_bl8 | input | 1 | Burst length select: 0 = 4, 1 = 8 |
| rd_cmd | input | 1 | READ command strobe |
| rd_tag | input | 4 | Identifier of the READ |
| issue | output | 1 | Internal issue pulse toward the column path |
| issue_tag | output | 4 | Tag of the READ being issued |
| dv | output | 1 | Read data valid window |
| dv_tag | output | 4 | Tag of the READ owning the window |
| err_busy | output | 1 | Write refused: READ in flight |
| err_illegal | output | 1 | Write refused: reserved AL or CL out of range |

## Verification
Take the edge that registers a READ as edge c. `issue` is due in the clock after edge c+AL. `dv` is due in the clocks after edges c+AL+CL through c+AL+CL+BL/2-1. The error flags are due in the single clock after the write edge.

The bench counts rising edges, records the edge that registers each READ, and derives every expected value from those counts. It compares all outputs at each falling edge, halfway between two updates. Refused writes are shown to have no effect by timing a later READ against the settings that were in force before the write.

// File: rtl/rdlt_pkg.sv
package rdlt_pkg;
   // result of a configuration write attempt
   typedef enum logic [1:0] {
      CFG_NONE  = 2'd0,
      CFG_TAKE  = 2'd1,
      CFG_BUSY  = 2'd2,
      CFG_BAD   = 2'd3
   } cfg_res_e;

   // clocks of data-valid per READ minus one
   function automatic logic [1:0] half_burst_m1(input logic bl8);
      return bl8 ? 2'd3 : 2'd1;
   endfunction
endpackage

// File: rtl/rdlt_cfg.sv
module rdlt_cfg #(
   parameter int AL_W   = 3,
   parameter int CL_W   = 3,
   parameter int MAX_AL = 4,
   parameter int MIN_CL = 3,
   parameter int MAX_CL = 7
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            we,
   input  logic [AL_W-1:0] al_in,
   input  logic [CL_W-1:0] cl_in,
   input  logic            bl8_in,
   input  logic            busy,
   output logic [AL_W-1:0] al_q,
   output logic [CL_W-1:0] cl_q,
   output logic            bl8_q,
   output logic            err_busy,
   output logic            err_illegal
);
   import rdlt_pkg::*;

   localparam logic [AL_W-1:0] AL_HI = AL_W'(MAX_AL);
   localparam logic [CL_W-1:0] CL_LO = CL_W'(MIN_CL);
   localparam logic [CL_W-1:0] CL_HI = CL_W'(MAX_CL);

   cfg_res_e res;

   always_comb begin
      if (!we)                                              res = CFG_NONE;
      else if (busy)                                        res = CFG_BUSY;
      else if (al_in > AL_HI || cl_in < CL_LO || cl_in > CL_HI) res = CFG_BAD;
      else                                                  res = CFG_TAKE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         al_q        <= '0;
         cl_q        <= CL_LO;
         bl8_q       <= 1'b0;
         err_busy    <= 1'b0;
         err_illegal <= 1'b0;
      end else begin
         err_busy    <= (res == CFG_BUSY);
         err_illegal <= (res == CFG_BAD);
         if (res == CFG_TAKE) begin
            al_q  <= al_in;
            cl_q  <= cl_in;
            bl8_q <= bl8_in;
         end
      end
   end
endmodule

// File: rtl/rdlt_pipe.sv
module rdlt_pipe #(
   parameter int DEPTH = 12,
   parameter int TAG_W = 4,
   parameter int IDX_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd,
   input  logic [TAG_W-1:0] tag,
   input  logic [IDX_W-1:0] iss_idx,
   input  logic [IDX_W-1:0] dat_idx,
   output logic             iss_vld,
   output logic [TAG_W-1:0] iss_tag,
   output logic             dat_vld,
   output logic [TAG_W-1:0] dat_tag,
   output logic             any_vld
);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH-1);

   logic [DEPTH-1:0] vld;
   logic [TAG_W-1:0] tg [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld[0] <= 1'b0;
         tg[0]  <= '0;
      end else begin
         vld[0] <= cmd;
         tg[0]  <= tag;
      end
   end

   for (genvar g = 1; g < DEPTH; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            vld[g] <= 1'b0;
            tg[g]  <= '0;
         end else begin
            vld[g] <= vld[g-1];
            tg[g]  <= tg[g-1];
         end
      end
   end

   assign iss_vld = (iss_idx <= LAST) ? vld[iss_idx] : 1'b0;
   assign iss_tag = (iss_idx <= LAST) ? tg[iss_idx]  : '0;
   assign dat_vld = (dat_idx <= LAST) ? vld[dat_idx] : 1'b0;
   assign dat_tag = (dat_idx <= LAST) ? tg[dat_idx]  : '0;
   assign any_vld = |vld;
endmodule

// File: rtl/rdlt_burst.sv
module rdlt_burst #(
   parameter int TAG_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [TAG_W-1:0] start_tag,
   input  logic             bl8,
   output logic             dv,
   output logic [TAG_W-1:0] dv_tag,
   output logic             active
);
   import rdlt_pkg::*;

   logic [1:0]       left;
   logic [TAG_W-1:0] tag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         left  <= '0;
         tag_q <= '0;
      end else if (start) begin
         left  <= half_burst_m1(bl8);
         tag_q <= start_tag;
      end else if (left != 2'd0) begin
         left  <= left - 2'd1;
      end
   end

   assign active = (left != 2'd0);
   assign dv     = start | active;
   assign dv_tag = start ? start_tag : tag_q;
endmodule

// File: rtl/rdlt_tracker.sv
module rdlt_tracker #(
   parameter int TAG_W  = 4,
   parameter int AL_W   = 3,
   parameter int CL_W   = 3,
   parameter int MAX_AL = 4,
   parameter int MIN_CL = 3,
   parameter int MAX_CL = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [AL_W-1:0]  cfg_al,
   input  logic [CL_W-1:0]  cfg_cl,
   input  logic             cfg_bl8,
   input  logic             rd_cmd,
   input  logic [TAG_W-1:0] rd_tag,
   output logic             issue,
   output logic [TAG_W-1:0] issue_tag,
   output logic             dv,
   output logic [TAG_W-1:0] dv_tag,
   output logic             err_busy,
   output logic             err_illegal
);
   localparam int DEPTH = MAX_AL + MAX_CL + 1;
   localparam int IDX_W = $clog2(DEPTH);

   if (MAX_AL < 4)                          begin : g_bad_al $error("MAX_AL below 4"); end
   if (MIN_CL < 1 || MAX_CL < MIN_CL)       begin : g_bad_cl $error("CL range empty"); end
   if (MAX_CL < 4)                          begin : g_low_cl $error("MAX_CL below 4"); end
   if ((1 << AL_W) <= MAX_AL)               begin : g_al_w   $error("AL_W too narrow"); end
   if ((1 << CL_W) <= MAX_CL)               begin : g_cl_w   $error("CL_W too narrow"); end
   if (IDX_W < AL_W || IDX_W < CL_W)        begin : g_idx_w  $error("index too narrow"); end

   logic [AL_W-1:0]  al_q;
   logic [CL_W-1:0]  cl_q;
   logic             bl8_q;
   logic             busy;
   logic             pipe_any;
   logic             burst_act;
   logic             start;
   logic [TAG_W-1:0] start_tag;
   logic [IDX_W-1:0] iss_idx;
   logic [IDX_W-1:0] dat_idx;

   assign iss_idx = IDX_W'(al_q);
   assign dat_idx = IDX_W'(al_q) + IDX_W'(cl_q);
   assign busy    = rd_cmd | pipe_any | burst_act;

   rdlt_cfg #(
      .AL_W(AL_W), .CL_W(CL_W), .MAX_AL(MAX_AL), .MIN_CL(MIN_CL), .MAX_CL(MAX_CL)
   ) u_cfg (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .al_in(cfg_al), .cl_in(cfg_cl),
      .bl8_in(cfg_bl8), .busy(busy), .al_q(al_q), .cl_q(cl_q), .bl8_q(bl8_q),
      .err_busy(err_busy), .err_illegal(err_illegal)
   );

   rdlt_pipe #(
      .DEPTH(DEPTH), .TAG_W(TAG_W), .IDX_W(IDX_W)
   ) u_pipe (
      .clk(clk), .rst_n(rst_n), .cmd(rd_cmd), .tag(rd_tag),
      .iss_idx(iss_idx), .dat_idx(dat_idx),
      .iss_vld(issue), .iss_tag(issue_tag),
      .dat_vld(start), .dat_tag(start_tag), .any_vld(pipe_any)
   );

   rdlt_burst #(
      .TAG_W(TAG_W)
   ) u_burst (
      .clk(clk), .rst_n(rst_n), .start(start), .start_tag(start_tag),
      .bl8(bl8_q), .dv(dv), .dv_tag(dv_tag), .active(burst_act)
   );
endmodule

// File: rtl/rdlt_checker.sv
module rdlt_checker #(
   parameter int AL_W   = 3,
   parameter int CL_W   = 3,
   parameter int MAX_AL = 4,
   parameter int MIN_CL = 3,
   parameter int MAX_CL = 7
) (
   input logic            clk,
   input logic            rst_n,
   input logic            cfg_we,
   input logic [AL_W-1:0] cfg_al,
   input logic [CL_W-1:0] cfg_cl,
   input logic            rd_cmd,
   input logic            issue,
   input logic            dv,
   input logic            err_busy,
   input logic            err_illegal,
   input logic            busy,
   input logic [AL_W-1:0] al_q,
   input logic [CL_W-1:0] cl_q
);
   localparam logic [AL_W-1:0] AL_HI = AL_W'(MAX_AL);
   localparam logic [CL_W-1:0] CL_LO = CL_W'(MIN_CL);
   localparam logic [CL_W-1:0] CL_HI = CL_W'(MAX_CL);

   assert_issue_al0_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_cmd && al_q == '0) |=> issue);

   assert_total_cl3_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_cmd && al_q == '0 && cl_q == CL_W'(3)) |=> ##3 dv);

   assert_min_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dv) |=> dv);

   assert_reserved_al_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && !busy && cfg_al > AL_HI) |=> (err_illegal && al_q == $past(al_q)));

   assert_cl_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && !busy && cfg_al <= AL_HI && (cfg_cl < CL_LO || cfg_cl > CL_HI))
      |=> (err_illegal && cl_q == $past(cl_q)));

   assert_busy_ignore_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && busy) |=> (err_busy && !err_illegal && al_q == $past(al_q) && cl_q == $past(cl_q)));
endmodule

bind rdlt_tracker rdlt_checker #(
   .AL_W(AL_W), .CL_W(CL_W), .MAX_AL(MAX_AL), .MIN_CL(MIN_CL), .MAX_CL(MAX_CL)
) u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_al(cfg_al), .cfg_cl(cfg_cl),
   .rd_cmd(rd_cmd), .issue(issue), .dv(dv), .err_busy(err_busy),
   .err_illegal(err_illegal), .busy(busy), .al_q(al_q), .cl_q(cl_q)
);

// File: tb/sim_rdlt_tracker.sv
`timescale 1ns/1ps
module sim_rdlt_tracker;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_we = 1'b0;
   logic [2:0] cfg_al = '0;
   logic [2:0] cfg_cl = '0;
   logic       cfg_bl8 = 1'b0;
   logic       rd_cmd = 1'b0;
   logic [3:0] rd_tag = '0;
   logic       issue, dv, err_busy, err_illegal;
   logic [3:0] issue_tag, dv_tag;

   int  cyc = 0;
   int  n_chk = 0;
   int  n_bad = 0;
   bit  done = 1'b0;

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   rdlt_tracker u0 (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_al(cfg_al), .cfg_cl(cfg_cl),
      .cfg_bl8(cfg_bl8), .rd_cmd(rd_cmd), .rd_tag(rd_tag), .issue(issue),
      .issue_tag(issue_tag), .dv(dv), .dv_tag(dv_tag), .err_busy(err_busy),
      .err_illegal(err_illegal)
   );

   // {al[13:11], cl[10:8], bl8[7], gap[6:3], reads[2:0]}
   localparam logic [13:0] VEC [6] = '{
      {3'd0, 3'd3, 1'b0, 4'd2, 3'd3},
      {3'd0, 3'd4, 1'b1, 4'd4, 3'd3},
      {3'd2, 3'd3, 1'b0, 4'd5, 3'd2},
      {3'd4, 3'd7, 1'b1, 4'd4, 3'd4},
      {3'd1, 3'd5, 1'b1, 4'd6, 3'd2},
      {3'd3, 3'd4, 1'b0, 4'd2, 3'd4}
   };

   task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s cyc=%0d actual=%h expected=%h", req, cyc, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   // write at a falling edge; flags checked one clock later
   task automatic cfg_write(input int al, input int cl, input bit bl8,
                            input bit with_rd, input bit e_busy, input bit e_ill, input string req);
      cfg_we = 1'b1; cfg_al = 3'(al); cfg_cl = 3'(cl); cfg_bl8 = bl8; rd_cmd = with_rd;
      @(negedge clk);
      cfg_we = 1'b0; rd_cmd = 1'b0;
      check(req, {10'd0, err_busy, err_illegal}, {10'd0, e_busy, e_ill});
      @(negedge clk);
      check(req, {10'd0, err_busy, err_illegal}, 12'd0);
   endtask

   // issue READs and compare every output each cycle against the edge counts
   task automatic run_vec(input int al, input int cl, input bit bl8, input int gap,
                          input int nrd, input int tbase, input bit do_cfg, input string req);
      int at [8];
      logic [3:0] tg [8];
      int lat, blen, last, k;
      logic e_iss, e_dv;
      logic [3:0] e_it, e_dt;
      if (do_cfg) cfg_write(al, cl, bl8, 1'b0, 1'b0, 1'b0, req);
      lat  = al + cl;
      blen = bl8 ? 4 : 2;
      for (int i = 0; i < nrd; i++) begin
         at[i] = cyc + 1 + i * gap;
         tg[i] = 4'(tbase + i * 5);
      end
      last = at[nrd-1] + lat + blen + 1;
      k = 0;
      while (cyc <= last) begin
         e_iss = 1'b0; e_dv = 1'b0; e_it = '0; e_dt = '0;
         for (int i = 0; i < nrd; i++) begin
            if (k > i || (k == i && at[i] <= cyc)) begin
               if (at[i] + al == cyc) begin e_iss = 1'b1; e_it = tg[i]; end
               if (cyc >= at[i] + lat && cyc < at[i] + lat + blen) begin
                  e_dv = 1'b1; e_dt = tg[i];
               end
            end
         end
         check(req, {issue, (issue ? issue_tag : 4'd0), dv, (dv ? dv_tag : 4'd0), err_busy, err_illegal},
                    {e_iss, e_it, e_dv, e_dt, 2'b00});
         if (k < nrd && at[k] == cyc + 1) begin
            rd_cmd = 1'b1; rd_tag = tg[k]; k++;
         end else begin
            rd_cmd = 1'b0;
         end
         @(negedge clk);
      end
      rd_cmd = 1'b0;
      idle(14);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      idle(3);
      // R10: outputs low during and after reset
      check("R10", {issue, dv, err_busy, err_illegal, 8'd0}, 12'd0);
      rst_n = 1'b1;
      idle(2);
      check("R10", {issue, dv, err_busy, err_illegal, 8'd0}, 12'd0);
      // R10: reset settings AL=0 CL=3 BL4; R1 at CL=3
      run_vec(0, 3, 1'b0, 3, 2, 1, 1'b0, "R10_R1");

      // table: R1 R2 R3 R6 R7 R8
      for (int v = 0; v < 6; v++) begin
         run_vec(int'(VEC[v][13:11]), int'(VEC[v][10:8]), VEC[v][7], int'(VEC[v][6:3]),
                 int'(VEC[v][2:0]), v * 3, 1'b1, "R1_R2_R3_R6_R7_R8");
      end

      // R4: reserved AL codes refused, settings stay AL=3 CL=4 BL4
      cfg_write(5, 4, 1'b1, 1'b0, 1'b0, 1'b1, "R4");
      cfg_write(7, 3, 1'b0, 1'b0, 1'b0, 1'b1, "R4");
      run_vec(3, 4, 1'b0, 2, 2, 9, 1'b0, "R4_kept");

      // R5: CL out of range refused
      cfg_write(1, 2, 1'b1, 1'b0, 1'b0, 1'b1, "R5");
      cfg_write(0, 0, 1'b0, 1'b0, 1'b0, 1'b1, "R5");
      run_vec(3, 4, 1'b0, 2, 1, 4, 1'b0, "R5_kept");

      // R9: write on READ edge, and write while READ in flight; busy wins over illegal
      cfg_write(0, 5, 1'b1, 1'b1, 1'b1, 1'b0, "R9");
      idle(2);
      cfg_write(6, 3, 1'b0, 1'b0, 1'b1, 1'b0, "R9");
      idle(16);
      run_vec(3, 4, 1'b0, 2, 1, 2, 1'b0, "R9_kept");

      // R7: back-to-back at BL/2 with BL8 at AL=0 CL=4
      run_vec(0, 4, 1'b1, 4, 4, 7, 1'b1, "R7");

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule